// File: doc/BRIEF.md
# Cache Tag Store with Index Compare

This block holds a table of cache tags: 8192 entries of 8 bits each, selected by a 13-bit index. A host writes tags into the table, reads them back over a data bus that has a separate output-enable, and runs compare cycles. In a compare cycle the byte on the data inputs is taken as a tag and checked against the entry at the given index. A hit flag comes back one clock later.

All controls are active low: select, write enable, output enable and bulk clear. The hit result has its own drive-enable, so several stores can feed one wired-OR line outside the block. When an instance is not selected it leaves that line alone. A bulk clear empties the whole table in two clock edges. Each entry carries a valid bit. The clear drops the lower half of the valid bits on the first edge and the upper half on the second. An entry whose valid bit is clear reads as 0x00.

Top module: `tagStore`

## Requirements
- R1: A write cycle (csN=0, weN=0, not clearing) stores din at the entry addressed by the 13-bit addr; index 0 and index 8191 are both reachable.
- R2: A read cycle (csN=0, weN=1, oeN=0) sampled at a rising edge makes doutOe=1 after that edge and puts the addressed entry on dout.
- R3: A compare cycle (csN=0, weN=1, oeN=1) sampled at a rising edge makes matchDrv=1 after that edge. matchHit is 1 only if all 8 bits of din equal the entry; a single differing bit gives 0.
- R4: With csN=1 at an edge, doutOe, matchDrv and matchHit are 0 after that edge, and weN has no effect on the table.
- R5: clrN sampled low at an edge begins a clear. After that edge and the next one, every entry reads 0x00. Writes are ignored on both edges.
- R6: A compare sampled while a clear is in progress (clrN low, or the edge that follows a clear start) reports a hit only for tag 0x00.
- R7: After reset every output is 0 and every entry reads 0x00.
- R8: matchHit is never 1 while matchDrv is 0, and doutOe and matchDrv are never 1 together.
- R9: A write cycle leaves doutOe and matchDrv at 0 after its edge, and dout reads 0 while doutOe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Select, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| clrN | input | 1 | Bulk clear request, active low |
| addr | input | 13 | Entry index |
| din | input | 8 | Write data, or the tag in a compare cycle |
| dout | output | 8 | Read data, valid while doutOe is 1 |
| doutOe | output | 1 | Drive enable for the read data bus |
| matchHit | output | 1 | Compare result: 1 on hit |
| matchDrv | output | 1 | Drive enable for the shared match line |

## Verification
The port assertions assume that the controls are settled at each rising edge and that reset is released away from an edge. The bench drives every input on the falling edge, so this holds. The clear assertions assume that no write reaches the table while a clear is running. The stimulus tests exactly that case: it attempts writes on both clear edges and then reads the affected entries back. It also drives long random runs that mix reads, writes, compares, deselects and clears. Compare tags are either the stored value, the stored value with one bit flipped, or 0x00 during a clear.

// File: rtl/tagPkg.sv
package tagPkg;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic wrEn;      // commit din into the table
    logic rdEn;      // load read data register
    logic cmpEn;     // load compare result register
    logic clrLo;     // drop valid bits of the lower half
    logic clrHi;     // drop valid bits of the upper half
    logic zeroView;  // clear in progress: all entries look like zero
  } ctrlStrb_t;

  typedef enum logic {
    CLR_IDLE = 1'b0,
    CLR_HIGH = 1'b1
  } clrState_t;

endpackage

// File: rtl/tagCtrl.sv
module tagCtrl
  import tagPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      csN,
  input  logic      weN,
  input  logic      oeN,
  input  logic      clrN,
  output ctrlStrb_t strb
);

  clrState_t clrState;
  clrState_t clrStateNext;
  logic      clearing;

  always_comb begin
    clrStateNext = CLR_IDLE;
    if (clrState == CLR_IDLE && !clrN) clrStateNext = CLR_HIGH;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) clrState <= CLR_IDLE;
    else       clrState <= clrStateNext;
  end

  assign clearing = !clrN || (clrState == CLR_HIGH);

  always_comb begin
    strb.wrEn     = !csN && !weN && !clearing;
    strb.rdEn     = !csN &&  weN && !oeN;
    strb.cmpEn    = !csN &&  weN &&  oeN;
    strb.clrLo    = !clrN && (clrState == CLR_IDLE);
    strb.clrHi    = (clrState == CLR_HIGH);
    strb.zeroView = clearing;
  end

  // R5
  clr_high_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrState == CLR_IDLE && !clrN) |=> (clrState == CLR_HIGH));

  // R5
  clr_high_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrState == CLR_HIGH) |=> (clrState == CLR_IDLE));

endmodule

// File: rtl/tagData.sv
module tagData
  import tagPkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              doutOe,
  output logic              matchHit,
  output logic              matchDrv
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int HALF  = DEPTH / 2;

  logic [DATA_W-1:0] tagMem [DEPTH];
  logic [DEPTH-1:0]  entryValid;
  logic [DATA_W-1:0] storedWord;

  // Tag array: no reset, the valid bits stand in for it
  always_ff @(posedge clk) begin
    if (strb.wrEn) tagMem[addr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entryValid <= '0;
    end else begin
      if (strb.clrLo) entryValid[HALF-1:0]     <= '0;
      if (strb.clrHi) entryValid[DEPTH-1:HALF] <= '0;
      if (strb.wrEn)  entryValid[addr]         <= 1'b1;
    end
  end

  assign storedWord = (strb.zeroView || !entryValid[addr]) ? '0 : tagMem[addr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dout     <= '0;
      doutOe   <= 1'b0;
      matchHit <= 1'b0;
      matchDrv <= 1'b0;
    end else begin
      dout     <= strb.rdEn ? storedWord : '0;
      doutOe   <= strb.rdEn;
      matchDrv <= strb.cmpEn;
      matchHit <= strb.cmpEn && (storedWord == din);
    end
  end

  // R5
  lower_cleared_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrLo |=> (entryValid[HALF-1:0] == '0));

  // R5
  upper_cleared_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrHi |=> (entryValid[DEPTH-1:HALF] == '0));

endmodule

// File: rtl/tagStore.sv
module tagStore
  import tagPkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              weN,
  input  logic              oeN,
  input  logic              clrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              doutOe,
  output logic              matchHit,
  output logic              matchDrv
);

  ctrlStrb_t strb;

  tagCtrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .csN  (csN),
    .weN  (weN),
    .oeN  (oeN),
    .clrN (clrN),
    .strb (strb)
  );

  tagData #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .addr     (addr),
    .din      (din),
    .dout     (dout),
    .doutOe   (doutOe),
    .matchHit (matchHit),
    .matchDrv (matchDrv)
  );

  // R2
  read_drives_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && weN && !oeN) |=> doutOe);

  // R3
  compare_drives_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && weN && oeN) |=> matchDrv);

  // R4
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (!doutOe && !matchDrv && !matchHit));

  // R6
  clear_compare_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && weN && oeN && !clrN && (din != '0)) |=> !matchHit);

  // R8
  hit_needs_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    matchHit |-> matchDrv);

  // R8
  no_dual_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(doutOe && matchDrv));

  // R9
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !weN) |=> (!doutOe && !matchDrv && dout == '0));

endmodule

// File: tb/sim_tagStore.sv
module sim_tagStore;

  localparam int AW = 13;
  localparam int DW = 8;
  localparam int NENT = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          csN = 1'b1, weN = 1'b1, oeN = 1'b1, clrN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          doutOe, matchHit, matchDrv;

  int checks = 0;
  int errors = 0;
  int cycleCnt = 0;
  bit done = 0;

  // behavioural reference
  byte unsigned refMem [NENT];
  bit           refBusy = 0;
  logic [DW-1:0] expDout;
  logic          expOe, expHit, expDrv;
  string         curTag;

  tagStore #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .weN(weN), .oeN(oeN), .clrN(clrN),
    .addr(addr), .din(din), .dout(dout), .doutOe(doutOe),
    .matchHit(matchHit), .matchDrv(matchDrv)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycleCnt++;
    if (cycleCnt > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one clock: inputs are already driven; compute expectation at the edge
  task automatic step(bit c, bit w, bit o, bit cl, int a, int d);
    bit clearing;
    csN = c; weN = w; oeN = o; clrN = cl; addr = AW'(a); din = DW'(d);
    @(posedge clk);
    clearing = !cl || refBusy;
    expOe   = !c && w && !o;
    expDrv  = !c && w && o;
    expDout = expOe ? (clearing ? 8'h00 : refMem[a]) : 8'h00;
    expHit  = expDrv && ((clearing ? 8'h00 : refMem[a]) == DW'(d));
    if (c) curTag = "R4";
    else if (!w) curTag = "R9";
    else if (!o) curTag = "R2";
    else curTag = clearing ? "R6" : "R3";
    if (clearing) foreach (refMem[i]) refMem[i] = 0;
    else if (!c && !w) refMem[a] = byte'(d);
    refBusy = !cl && !refBusy;
    @(negedge clk);
    check(curTag, "doutOe", int'(doutOe), int'(expOe));
    check(curTag, "dout", int'(dout), int'(expDout));
    check(curTag, "matchDrv", int'(matchDrv), int'(expDrv));
    check("R8", "matchHit", int'(matchHit), int'(expHit));
  endtask

  task automatic wr(int a, int d);  step(0, 0, 1, 1, a, d); endtask
  task automatic rd(int a);         step(0, 1, 0, 1, a, 0); endtask
  task automatic cmp(int a, int t); step(0, 1, 1, 1, a, t); endtask

  initial begin
    foreach (refMem[i]) refMem[i] = 0;
    repeat (3) @(negedge clk);
    // R7 reset state
    check("R7", "doutOe", int'(doutOe), 0);
    check("R7", "matchDrv", int'(matchDrv), 0);
    check("R7", "dout", int'(dout), 0);
    rstN = 1'b1;
    @(negedge clk);
    rd(100); check("R7", "entry after reset", int'(dout), 0);
    cmp(100, 0); check("R7", "zero tag hit", int'(matchHit), 1);

    // R1 edges of the index space
    wr(0, 8'h5a); wr(NENT-1, 8'ha5);
    rd(0);      check("R1", "index 0", int'(dout), 8'h5a);
    rd(NENT-1); check("R1", "index max", int'(dout), 8'ha5);

    // R3 hit and one-bit miss
    wr(77, 8'h3c);
    cmp(77, 8'h3c); check("R3", "exact tag hit", int'(matchHit), 1);
    cmp(77, 8'h3d); check("R3", "one-bit miss", int'(matchHit), 0);
    cmp(77, 8'hbc); check("R3", "msb miss", int'(matchHit), 0);

    // R4 deselected write has no effect
    step(1, 0, 0, 1, 77, 8'hff);
    check("R4", "doutOe deselected", int'(doutOe), 0);
    rd(77); check("R4", "entry untouched", int'(dout), 8'h3c);

    // R5 clear: write on both clear edges is dropped
    wr(10, 8'h11); wr(NENT-2, 8'h22);
    step(0, 0, 1, 0, 10, 8'h99);
    step(0, 0, 1, 1, NENT-2, 8'h98);
    rd(10);     check("R5", "lower entry zero", int'(dout), 0);
    rd(NENT-2); check("R5", "upper entry zero", int'(dout), 0);
    rd(0);      check("R5", "entry 0 zero", int'(dout), 0);

    // R6 compare during clear
    wr(20, 8'h44);
    step(0, 1, 1, 0, 20, 8'h44); check("R6", "nonzero tag in clear", int'(matchHit), 0);
    step(0, 1, 1, 1, 20, 8'h00); check("R6", "zero tag in clear", int'(matchHit), 1);
    wr(20, 8'h44);
    cmp(20, 8'h44); check("R3", "hit after clear", int'(matchHit), 1);

    // random mix
    for (int n = 0; n < 6000; n++) begin
      int r = $urandom_range(0, 99);
      int a = (r % 2 == 0) ? $urandom_range(0, 15) : $urandom_range(NENT-16, NENT-1);
      int t = refMem[a];
      if ($urandom_range(0, 2) == 0) t = t ^ (1 << $urandom_range(0, 7));
      if (r < 30)      wr(a, $urandom_range(0, 255));
      else if (r < 50) rd(a);
      else if (r < 78) cmp(a, t);
      else if (r < 90) step(1, $urandom_range(0, 1), $urandom_range(0, 1), 1, a, $urandom_range(0, 255));
      else if (r < 95) step(0, 1, 1, 0, a, ($urandom_range(0, 1) == 0) ? 0 : t);
      else             step(0, 0, 1, 0, a, $urandom_range(0, 255));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule